// File: doc/BRIEF.md
# Parallel NOR Word Program Sequencer

This block programs a single data word into an asynchronous parallel NOR flash device over a simple strobed bus. A host hands it a target address, a data word and a bypass flag with a one-cycle start request. The block then issues the program command cycles, writes the datum, waits a programmable settling time and polls the device status. The device reports that it is busy by flipping bit 6 on every read. Once that bit stops flipping, or once a controller-side timeout runs out, two further confirming reads decide the outcome.

Each result is reported with a one-cycle done pulse and a two-bit error code. Any failure is followed by a reset command to the device before the block returns to idle. Bus timing is expressed in whole clock cycles. A write is an address/data setup cycle followed by one cycle with the write strobe low. A read is an address cycle followed by one cycle with the output-enable strobe low, and the data input is captured at the clock edge that ends that cycle. The data bus is built from `LANES` byte lanes. Command bytes are repeated in every lane.

The controller has ten named states. ST_IDLE moves to ST_WR_SETUP on start (transition "accept"). ST_WR_SETUP moves to ST_WR_STROBE ("strobe"). ST_WR_STROBE loops back to ST_WR_SETUP for the next command step ("next step"), or moves to ST_PGM_WAIT after the data write ("programmed"). ST_PGM_WAIT moves to ST_RD_SETUP when the settling counter reaches zero ("settled"). ST_RD_SETUP moves to ST_RD_STROBE ("read"). ST_RD_STROBE returns to ST_RD_SETUP for the second read of a pair, for another poll pair, or for the first confirming read ("poll again" / "confirm"). After the second confirming read it moves to ST_JUDGE ("verdict"). ST_JUDGE moves to ST_FINISH on success ("pass") or to ST_ABORT_SETUP on any failure ("fail"). ST_ABORT_SETUP moves to ST_ABORT_STROBE ("reset cmd"). ST_ABORT_STROBE moves to ST_FINISH ("aborted"). ST_FINISH returns to ST_IDLE ("report").

Top module: `nor_word_prog`

## Requirements
- R1: After reset `ready` is 1, `done` is 0 and all three bus strobes (`fl_ce_n`, `fl_we_n`, `fl_oe_n`) are high. The strobes stay high whenever `ready` is 1.
- R2: With `use_bypass` low, exactly four bus writes are issued in this order: 0xAA to UNLOCK_A, 0x55 to UNLOCK_B, 0xA0 to UNLOCK_A, then the datum to the target address.
- R3: With `use_bypass` high, exactly two bus writes are issued: 0xA0 to UNLOCK_A, then the datum to the target address.
- R4: Every write holds `fl_we_n` low for exactly one cycle with `fl_ce_n` low. Every read holds `fl_oe_n` low for one cycle. `fl_we_n` and `fl_oe_n` are never low together.
- R5: The first status read strobe comes exactly PROG_WAIT+3 cycles after the data write strobe.
- R6: Reads come in pairs at the target address. Polling repeats while bit 6 of some lane differs between the two reads of a pair and the poll timer has not reached zero. The poll timer is loaded with POLL_LIMIT when polling starts and counts down once per cycle.
- R7: After polling stops, two confirming reads are taken. The result is success (code 0) only if both of them equal the datum. A mismatch in only the first one is still a failure.
- R8: If the poll timer had expired while bit 6 was still toggling, and some lane has bit 6 differing between the confirming reads with bit 5 set in the second of them, the code is 1 (device-internal timeout).
- R9: If the poll timer had expired and no such lane has bit 5 set, the code is 2 (controller timeout).
- R10: If the confirming reads fail and no timeout was recorded, the code is 3 (undecodable failure).
- R11: After any failure, and before `done`, a write of 0xF0 to address 0 is issued. On success no write follows the data write.
- R12: `done` is a one-cycle pulse, and `err_code` is valid during it. `ready` is low from acceptance until the cycle after `done`, when it returns high. A start request made while busy is ignored.
- R13: Bit 5 has no effect during polling. A device that shows bit 5 set while busy but finishes before the timeout yields code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to program one word, taken only while ready |
| ready | output | 1 | Block idle and able to accept start |
| tgt_addr | input | AW | Target word address |
| tgt_data | input | DW | Word to program |
| use_bypass | input | 1 | Issue the shortened single-command program sequence |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | Result: 0 ok, 1 device timeout, 2 controller timeout, 3 unknown |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | DW | Flash write data |
| fl_din | input | DW | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The assertions assume that `fl_din` is stable during a read strobe cycle, and that the host holds the request fields steady only for the cycle in which `start` is sampled. The bench meets both conditions. Its flash model changes its read value only at the clock edge that ends a read strobe, and start is driven for a single cycle away from the clock edge. The model derives each returned value only from the number of reads seen since the last write. This keeps the status sequence deterministic for busy, stuck-busy, glitching and wrong-value devices.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_PGM_WAIT,
        ST_RD_SETUP,
        ST_RD_STROBE,
        ST_JUDGE,
        ST_ABORT_SETUP,
        ST_ABORT_STROBE,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_DEV_TMO = 2'd1,
        RES_CTL_TMO = 2'd2,
        RES_UNKNOWN = 2'd3
    } result_t;

    localparam logic [7:0] CMD_UNLOCK_1 = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_2 = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_RESET    = 8'hF0;

    localparam int BUSY_BIT = 6;
    localparam int TMO_BIT  = 5;

    localparam logic [1:0] STEP_FIRST  = 2'd0;
    localparam logic [1:0] STEP_SHORT  = 2'd2;
    localparam logic [1:0] STEP_DATUM  = 2'd3;

endpackage

// File: rtl/nor_cmd_rom.sv
module nor_cmd_rom
    import nor_seq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LANES = 1,
    parameter int DW    = 8 * LANES,
    parameter logic [AW-1:0] UNLOCK_A = 'h555,
    parameter logic [AW-1:0] UNLOCK_B = 'h2AA
) (
    input  logic [1:0]    step,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] tgt_data,
    output logic [AW-1:0] cyc_addr,
    output logic [DW-1:0] cyc_data
);
    logic [7:0]    cmd_byte;
    logic [DW-1:0] cmd_word;

    always_comb begin
        unique case (step)
            2'd0:    cmd_byte = CMD_UNLOCK_1;
            2'd1:    cmd_byte = CMD_UNLOCK_2;
            default: cmd_byte = CMD_PROGRAM;
        endcase
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign cmd_word[8*ln +: 8] = cmd_byte;
    end

    always_comb begin
        unique case (step)
            2'd1:       cyc_addr = UNLOCK_B;
            STEP_DATUM: cyc_addr = tgt_addr;
            default:    cyc_addr = UNLOCK_A;
        endcase
        cyc_data = (step == STEP_DATUM) ? tgt_data : cmd_word;
    end
endmodule

// File: rtl/nor_tick_timer.sv
module nor_tick_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          run,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/nor_pair_judge.sv
module nor_pair_judge
    import nor_seq_pkg::*;
#(
    parameter int LANES = 1,
    parameter int DW    = 8 * LANES
) (
    input  logic [DW-1:0] rd_a,
    input  logic [DW-1:0] rd_b,
    input  logic [DW-1:0] expect_val,
    input  logic          timed_out,
    output logic          toggling,
    output result_t       verdict
);
    logic [LANES-1:0] lane_tog;
    logic [LANES-1:0] lane_dev;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign lane_tog[ln] = rd_a[8*ln + BUSY_BIT] ^ rd_b[8*ln + BUSY_BIT];
        assign lane_dev[ln] = lane_tog[ln] & rd_b[8*ln + TMO_BIT];
    end

    assign toggling = |lane_tog;

    always_comb begin
        if ((rd_a == expect_val) && (rd_b == expect_val)) begin
            verdict = RES_OK;
        end else if (timed_out) begin
            verdict = (|lane_dev) ? RES_DEV_TMO : RES_CTL_TMO;
        end else begin
            verdict = RES_UNKNOWN;
        end
    end
endmodule

// File: rtl/nor_word_prog.sv
module nor_word_prog
    import nor_seq_pkg::*;
#(
    parameter int AW         = 16,
    parameter int LANES      = 1,
    parameter int DW         = 8 * LANES,
    parameter logic [AW-1:0] UNLOCK_A = 'h555,
    parameter logic [AW-1:0] UNLOCK_B = 'h2AA,
    parameter int PROG_WAIT  = 5,
    parameter int POLL_LIMIT = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          ready,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] tgt_data,
    input  logic          use_bypass,
    output logic          done,
    output logic [1:0]    err_code,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    input  logic [DW-1:0] fl_din,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int MAXCNT = (PROG_WAIT > POLL_LIMIT) ? PROG_WAIT : POLL_LIMIT;
    localparam int TW     = $clog2(MAXCNT + 1);

    seq_state_t    state, nxt;
    logic [1:0]    step;
    logic          rd_sel;
    logic          confirm;
    logic          tmo_hit;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_data;
    logic [DW-1:0] rd_first;
    logic [DW-1:0] rd_second;
    result_t       err_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_run;
    logic          tmr_zero;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_data;
    logic [DW-1:0] judge_b;
    logic          pair_tog;
    result_t       verdict;
    logic          keep_poll;

    nor_cmd_rom #(
        .AW(AW), .LANES(LANES), .DW(DW),
        .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
    ) u_rom (
        .step(step), .tgt_addr(lat_addr), .tgt_data(lat_data),
        .cyc_addr(rom_addr), .cyc_data(rom_data)
    );

    nor_tick_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .run(tmr_run), .zero(tmr_zero)
    );

    assign judge_b = (state == ST_JUDGE) ? rd_second : fl_din;

    nor_pair_judge #(.LANES(LANES), .DW(DW)) u_judge (
        .rd_a(rd_first), .rd_b(judge_b), .expect_val(lat_data),
        .timed_out(tmo_hit), .toggling(pair_tog), .verdict(verdict)
    );

    assign keep_poll = pair_tog && !tmr_zero;
    assign tmr_run   = (state == ST_PGM_WAIT) || (state == ST_RD_SETUP) ||
                       (state == ST_RD_STROBE);

    // next-state and timer control
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE:         if (start) nxt = ST_WR_SETUP;
            ST_WR_SETUP:     nxt = ST_WR_STROBE;
            ST_WR_STROBE: begin
                if (step == STEP_DATUM) begin
                    nxt      = ST_PGM_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PROG_WAIT);
                end else begin
                    nxt = ST_WR_SETUP;
                end
            end
            ST_PGM_WAIT: begin
                if (tmr_zero) begin
                    nxt      = ST_RD_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(POLL_LIMIT);
                end
            end
            ST_RD_SETUP:     nxt = ST_RD_STROBE;
            ST_RD_STROBE:    nxt = (rd_sel && confirm) ? ST_JUDGE : ST_RD_SETUP;
            ST_JUDGE:        nxt = (verdict == RES_OK) ? ST_FINISH : ST_ABORT_SETUP;
            ST_ABORT_SETUP:  nxt = ST_ABORT_STROBE;
            ST_ABORT_STROBE: nxt = ST_FINISH;
            ST_FINISH:       nxt = ST_IDLE;
            default:         nxt = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            step      <= STEP_FIRST;
            rd_sel    <= 1'b0;
            confirm   <= 1'b0;
            tmo_hit   <= 1'b0;
            lat_addr  <= '0;
            lat_data  <= '0;
            rd_first  <= '0;
            rd_second <= '0;
            err_q     <= RES_OK;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        lat_addr <= tgt_addr;
                        lat_data <= tgt_data;
                        step     <= use_bypass ? STEP_SHORT : STEP_FIRST;
                        rd_sel   <= 1'b0;
                        confirm  <= 1'b0;
                        tmo_hit  <= 1'b0;
                    end
                end
                ST_WR_STROBE: begin
                    if (step != STEP_DATUM) step <= step + 2'd1;
                end
                ST_RD_STROBE: begin
                    if (!rd_sel) begin
                        rd_first <= fl_din;
                        rd_sel   <= 1'b1;
                    end else begin
                        rd_second <= fl_din;
                        rd_sel    <= 1'b0;
                        if (!confirm && !keep_poll) begin
                            confirm <= 1'b1;
                            tmo_hit <= pair_tog && tmr_zero;
                        end
                    end
                end
                ST_JUDGE: err_q <= verdict;
                default: ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        ready    = (state == ST_IDLE);
        done     = (state == ST_FINISH);
        err_code = err_q;
        fl_ce_n  = 1'b1;
        fl_we_n  = 1'b1;
        fl_oe_n  = 1'b1;
        fl_addr  = '0;
        fl_dout  = '0;
        unique case (state)
            ST_WR_SETUP, ST_WR_STROBE: begin
                fl_ce_n = 1'b0;
                fl_we_n = (state != ST_WR_STROBE);
                fl_addr = rom_addr;
                fl_dout = rom_data;
            end
            ST_RD_SETUP, ST_RD_STROBE: begin
                fl_ce_n = 1'b0;
                fl_oe_n = (state != ST_RD_STROBE);
                fl_addr = lat_addr;
            end
            ST_ABORT_SETUP, ST_ABORT_STROBE: begin
                fl_ce_n = 1'b0;
                fl_we_n = (state != ST_ABORT_STROBE);
                fl_dout = {LANES{CMD_RESET}};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nor_word_prog_chk.sv
module nor_word_prog_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ready,
    input logic          done,
    input logic [1:0]    err_code,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_dout,
    input logic          fl_ce_n,
    input logic          fl_we_n,
    input logic          fl_oe_n
);
    localparam logic [DW-1:0] RST_WORD = {(DW/8){8'hF0}};

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (fl_ce_n && fl_we_n && fl_oe_n)); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_oe_n && !fl_ce_n)); // R4
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |=> fl_we_n); // R4
    AST_OE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |=> fl_oe_n); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready)); // R12
    AST_FAIL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 2'd0) |->
            $past(!fl_we_n && fl_dout == RST_WORD && fl_addr == '0)); // R11
    AST_OK_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == 2'd0) |-> $past(fl_we_n)); // R11
endmodule

bind nor_word_prog nor_word_prog_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .done(done),
    .err_code(err_code), .fl_addr(fl_addr), .fl_dout(fl_dout),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
);

// File: tb/sim_nor_word_prog.sv
`timescale 1ns/1ps
module sim_nor_word_prog;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int PW = 5;
    localparam int PL = 40;
    localparam logic [AW-1:0] UA = 16'h0555;
    localparam logic [AW-1:0] UB = 16'h02AA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          ready;
    logic [AW-1:0] tgt_addr = '0;
    logic [DW-1:0] tgt_data = '0;
    logic          use_bypass = 1'b0;
    logic          done;
    logic [1:0]    err_code;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dout;
    logic [DW-1:0] fl_din;
    logic          fl_ce_n, fl_we_n, fl_oe_n;

    always #5 clk = ~clk;

    nor_word_prog #(.AW(AW), .LANES(1), .DW(DW), .UNLOCK_A(UA), .UNLOCK_B(UB),
                    .PROG_WAIT(PW), .POLL_LIMIT(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data), .use_bypass(use_bypass),
        .done(done), .err_code(err_code), .fl_addr(fl_addr), .fl_dout(fl_dout),
        .fl_din(fl_din), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    // flash model configuration (set by tasks)
    int         m_busy = 0;
    logic       m_stuck = 1'b0;
    logic       m_dq5 = 1'b0;
    int         m_glitch = -1;
    logic [7:0] m_gval = 8'h00;
    logic [7:0] m_final = 8'h00;

    // monitor state
    logic [AW-1:0] wa [256];
    logic [7:0]    wd [256];
    int wcnt = 0, rd_n = 0, done_cnt = 0, cyc = 0;
    int last_we_cyc = 0, first_rd_cyc = 0, overlap = 0;
    logic got_rd = 1'b0;

    int total_n = 0, bad_n = 0;

    function automatic logic [7:0] mval(int n, int busy, logic stuck, logic dq5,
                                        int gl, logic [7:0] gv, logic [7:0] fin);
        logic [7:0] v;
        if (n == gl)                v = gv;
        else if (stuck || n < busy) v = {~fin[7], n[0], dq5, 5'b0};
        else                        v = fin;
        return v;
    endfunction

    assign fl_din = mval(rd_n, m_busy, m_stuck, m_dq5, m_glitch, m_gval, m_final);

    always @(posedge clk) begin
        if (rst_n) begin
            cyc <= cyc + 1;
            if (!fl_we_n && !fl_oe_n) overlap <= overlap + 1;
            if (!fl_ce_n && !fl_we_n) begin
                wa[wcnt[7:0]] <= fl_addr;
                wd[wcnt[7:0]] <= fl_dout;
                wcnt        <= wcnt + 1;
                rd_n        <= 0;
                last_we_cyc <= cyc;
                got_rd      <= 1'b0;
            end
            if (!fl_ce_n && !fl_oe_n) begin
                rd_n <= rd_n + 1;
                if (!got_rd) begin
                    first_rd_cyc <= cyc;
                    got_rd       <= 1'b1;
                end
            end
            if (done) done_cnt <= done_cnt + 1;
        end
    end

    task automatic chk(input logic cond, input string req, input int act, input int exp);
        total_n++;
        if (!cond) begin
            bad_n++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input int busy, input logic stuck, input logic dq5,
                         input int gl, input logic [7:0] gv, input logic [7:0] fin);
        m_busy = busy; m_stuck = stuck; m_dq5 = dq5;
        m_glitch = gl; m_gval = gv; m_final = fin;
    endtask

    task automatic do_op(input logic [AW-1:0] a, input logic [7:0] d, input logic byp,
                         output logic [1:0] err_o);
        bit seen = 0;
        @(negedge clk);
        tgt_addr = a; tgt_data = d; use_bypass = byp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
        chk(seen, "R12 done seen", int'(seen), 1);
        err_o = err_code;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(ready == 1'b1 && done == 1'b0, "R1 ready/done", {ready, done}, 2'b10);
        chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    endtask

    task automatic t_normal();
        logic [1:0] e; int b;
        model(0, 0, 0, -1, 8'h00, 8'h5A);
        b = wcnt;
        do_op(16'h1234, 8'h5A, 1'b0, e);
        chk(e == 2'd0, "R7 normal ok", e, 0);
        chk(wcnt - b == 4, "R2 write count", wcnt - b, 4);
        chk(wa[b[7:0]] == UA && wd[b[7:0]] == 8'hAA, "R2 first cycle", wd[b[7:0]], 8'hAA);
        chk(wa[8'(b+1)] == UB && wd[8'(b+1)] == 8'h55, "R2 second cycle", wd[8'(b+1)], 8'h55);
        chk(wa[8'(b+2)] == UA && wd[8'(b+2)] == 8'hA0, "R2 third cycle", wd[8'(b+2)], 8'hA0);
        chk(wa[8'(b+3)] == 16'h1234 && wd[8'(b+3)] == 8'h5A, "R2 data cycle",
            wa[8'(b+3)], 16'h1234);
        chk(first_rd_cyc - last_we_cyc == PW + 3, "R5 settle gap",
            first_rd_cyc - last_we_cyc, PW + 3);
        chk(rd_n == 4, "R6 idle device read count", rd_n, 4);
    endtask

    task automatic t_bypass();
        logic [1:0] e; int b;
        model(0, 0, 0, -1, 8'h00, 8'hC3);
        b = wcnt;
        do_op(16'h0040, 8'hC3, 1'b1, e);
        chk(e == 2'd0, "R3 bypass ok", e, 0);
        chk(wcnt - b == 2, "R3 write count", wcnt - b, 2);
        chk(wa[b[7:0]] == UA && wd[b[7:0]] == 8'hA0, "R3 command cycle", wd[b[7:0]], 8'hA0);
        chk(wa[8'(b+1)] == 16'h0040 && wd[8'(b+1)] == 8'hC3, "R3 data cycle",
            wd[8'(b+1)], 8'hC3);
    endtask

    task automatic t_busy_dq5();
        logic [1:0] e; int b;
        model(6, 0, 1, -1, 8'h00, 8'h3C);
        b = wcnt;
        do_op(16'h0100, 8'h3C, 1'b0, e);
        chk(e == 2'd0, "R13 bit5 ignored while busy", e, 0);
        chk(rd_n == 10, "R6 poll while toggling", rd_n, 10);
        chk(wcnt - b == 4, "R11 no reset on success", wcnt - b, 4);
    endtask

    task automatic t_dev_tmo();
        logic [1:0] e; int b;
        model(0, 1, 1, -1, 8'h00, 8'h77);
        b = wcnt;
        do_op(16'h0200, 8'h77, 1'b0, e);
        chk(e == 2'd1, "R8 device timeout", e, 1);
        chk(wcnt - b == 5 && wa[8'(b+4)] == '0 && wd[8'(b+4)] == 8'hF0,
            "R11 reset after device timeout", wd[8'(b+4)], 8'hF0);
    endtask

    task automatic t_ctl_tmo();
        logic [1:0] e; int b;
        model(0, 1, 0, -1, 8'h00, 8'h11);
        b = wcnt;
        do_op(16'h0300, 8'h11, 1'b0, e);
        chk(e == 2'd2, "R9 controller timeout", e, 2);
        chk(wcnt - b == 5 && wd[8'(b+4)] == 8'hF0, "R11 reset after ctl timeout",
            wd[8'(b+4)], 8'hF0);
    endtask

    task automatic t_mismatch();
        logic [1:0] e; int b;
        model(0, 0, 0, -1, 8'h00, 8'h81);
        b = wcnt;
        do_op(16'h0400, 8'h80, 1'b0, e);
        chk(e == 2'd3, "R10 wrong value no timeout", e, 3);
        chk(wcnt - b == 5 && wd[8'(b+4)] == 8'hF0, "R11 reset after mismatch",
            wd[8'(b+4)], 8'hF0);
    endtask

    task automatic t_glitch();
        logic [1:0] e;
        model(0, 0, 0, 2, 8'h24, 8'h66);
        do_op(16'h0500, 8'h66, 1'b0, e);
        chk(e == 2'd3, "R7 first confirm read wrong", e, 3);
        model(0, 0, 0, 3, 8'h24, 8'h66);
        do_op(16'h0501, 8'h66, 1'b0, e);
        chk(e == 2'd3, "R7 second confirm read wrong", e, 3);
    endtask

    task automatic t_handshake();
        int b, dc; bit seen = 0;
        model(4, 0, 0, -1, 8'h00, 8'h99);
        b = wcnt; dc = done_cnt;
        @(negedge clk);
        tgt_addr = 16'h0600; tgt_data = 8'h99; use_bypass = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(ready == 1'b0, "R12 ready low while busy", ready, 0);
        tgt_addr = 16'h0777; tgt_data = 8'h12; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin seen = 1; break; end
            chk(ready == 1'b0, "R12 ready low until done", ready, 0);
            @(negedge clk);
        end
        chk(seen && err_code == 2'd0, "R12 result on done", err_code, 0);
        @(negedge clk);
        chk(ready == 1'b1 && done == 1'b0, "R12 done one cycle, ready back", {ready, done}, 2'b10);
        repeat (4) @(negedge clk);
        chk(done_cnt - dc == 1, "R12 busy start ignored", done_cnt - dc, 1);
        chk(wcnt - b == 4 && wa[8'(b+3)] == 16'h0600, "R12 target kept",
            wa[8'(b+3)], 16'h0600);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total_n++; bad_n++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total_n, bad_n);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_bypass();
        t_busy_dq5();
        t_dev_tmo();
        t_ctl_tmo();
        t_mismatch();
        t_glitch();
        t_handshake();
        chk(overlap == 0, "R4 strobes never overlap", overlap, 0);
        $display("test done: total=%0d bad=%0d", total_n, bad_n);
        $finish;
    end
endmodule